// File: doc/BRIEF.md
# Clock Source Enable and Selection Controller

This block keeps the on/off state and readiness of two oscillators: an on-die oscillator that is trimmed at startup, and an off-die oscillator. It also decides which source drives the system clock. Software reaches it through a small word-addressed register bus. Hardware events override what software has written. A low-power exit turns the on-die oscillator back on. A low-power entry turns the off-die oscillator off. A failure of the off-die oscillator while it feeds the system clock sends the selection back to the on-die source.

Software requests a source by writing a 2-bit code. The block reports the source that is actually in use in a separate read-only status field. That status follows the request only once the requested oscillator reports ready. A disable request is refused for any oscillator the system clock depends on. After a disable, the on-die ready flag does not drop at once: it lingers for a fixed number of oscillator periods, counted on a tick input.

Top module: `clk_src_ctrl`

## Requirements
- R1: On a synchronous reset the on-die enable is 1 and the off-die enable is 0. The request and status codes are both 00. The trim field is 16. The control word at offset 0x00 reads with the calibration byte from `cal_init` in bits 23:16. The configuration word at offset 0x04 reads 0.
- R2: The control word carries the enables at bit 0 (on-die) and bit 1 (off-die), and the ready flags at bit 4 (on-die) and bit 5 (off-die). A ready flag rises only in the cycle after its enable and its stable input are both high. Writes to bits 5:4 are discarded.
- R3: After the on-die enable goes low, its ready flag falls at the edge that samples the sixth `int_tick` (parameter DROP_TICKS). Setting the enable again before that keeps the flag up.
- R4: A `lp_exit` pulse sets the on-die enable in the next cycle, whatever software writes in that cycle.
- R5: A `lp_enter` pulse clears the off-die enable in the next cycle, whatever software writes in that cycle.
- R6: A write of 0 to the on-die enable is ignored while the request code or the status code is 00.
- R7: A write of 0 to the off-die enable is ignored while the status code is 01 (off-die direct) or 10 (multiplied clock derived from the off-die oscillator).
- R8: An `ext_fail` while the status code is 01 or 10 makes the status 00, rewrites the request to 00, and sets the on-die enable, all in the next cycle.
- R9: The request field sits in bits 1:0 of the word at 0x04 and is read-write. The status field sits in bits 3:2 and is read-only. The codes are 00 on-die, 01 off-die, 10 derived from off-die; a write of 11 is discarded. The status takes the request's value one cycle after the two differ and the requested oscillator's ready flag is high. Code 00 needs the on-die flag; 01 and 10 need the off-die flag.
- R10: The trim field sits in bits 12:8 of the control word and is written only when byte enable 1 is set. `trim_out` is the 9-bit sum of the calibration byte and the trim field.
- R11: A read of any word other than 0x00 and 0x04 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for a write |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| cal_init | input | 8 | Calibration byte captured at reset |
| int_stable | input | 1 | On-die oscillator reports stable output |
| int_tick | input | 1 | One pulse per on-die oscillator period |
| ext_stable | input | 1 | Off-die oscillator reports stable output |
| lp_enter | input | 1 | Pulse on entry to a low-power mode |
| lp_exit | input | 1 | Pulse on exit from a low-power mode |
| ext_fail | input | 1 | Off-die oscillator failure flag |
| int_osc_en | output | 1 | On-die oscillator enable |
| ext_osc_en | output | 1 | Off-die oscillator enable |
| clk_sel | output | 2 | Source code currently driving the system clock |
| trim_out | output | 9 | Effective trim value |

## Verification
The bench builds the block with the default DROP_TICKS of 6 and ADDR_W of 8. It pulses `int_tick` every third cycle, so one disable window spans about eighteen cycles. That is long enough to re-enable the on-die oscillator part-way through the window, and to watch the flag fall at the exact edge. The oscillators are modelled as delayed copies of their enables. This makes the window in which a switch request waits for readiness visible to the reference model on every clock. It also makes the fallback and low-power overrides collide with the protected-source rules.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam int REG_W     = 32;
    localparam int CTRL_WORD = 0;
    localparam int CFG_WORD  = 1;
    localparam logic [4:0] TRIM_RST = 5'd16;

    typedef enum logic [1:0] {
        SRC_INT = 2'b00,
        SRC_EXT = 2'b01,
        SRC_MUL = 2'b10,
        SRC_BAD = 2'b11
    } src_e;

    typedef struct packed {
        logic [7:0] rsv3;
        logic [7:0] cal;
        logic [2:0] rsv2;
        logic [4:0] trim;
        logic [1:0] rsv1;
        logic       ext_rdy;
        logic       int_rdy;
        logic [1:0] rsv0;
        logic       ext_en;
        logic       int_en;
    } ctrl_t;

    function automatic logic needs_ext(src_e s);
        return (s == SRC_EXT) || (s == SRC_MUL);
    endfunction

endpackage

// File: rtl/clkctl_ready.sv
module clkctl_ready #(
    parameter int DROP_TICKS = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic stable,
    input  logic tick,
    output logic rdy
);
    generate
        if (DROP_TICKS == 0) begin : g_direct
            logic unused_tick;
            assign unused_tick = tick;
            always_ff @(posedge clk) begin
                if (rst) rdy <= 1'b0;
                else     rdy <= en & stable;
            end
        end else begin : g_count
            localparam int CW = $clog2(DROP_TICKS + 1);
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst) begin
                    rdy <= 1'b0;
                    cnt <= '0;
                end else if (en) begin
                    rdy <= stable;
                    cnt <= '0;
                end else if (rdy && tick) begin
                    if (cnt == CW'(DROP_TICKS - 1)) begin
                        rdy <= 1'b0;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/clkctl_switch.sv
module clkctl_switch
    import clkctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_code,
    input  logic       int_rdy,
    input  logic       ext_rdy,
    input  logic       fail,
    output src_e       sw,
    output src_e       sws
);
    logic target_rdy;
    assign target_rdy = (sw == SRC_INT) ? int_rdy : ext_rdy;

    always_ff @(posedge clk) begin
        if (rst) begin
            sw  <= SRC_INT;
            sws <= SRC_INT;
        end else if (fail) begin
            sw  <= SRC_INT;
            sws <= SRC_INT;
        end else begin
            if (wr_en && src_e'(wr_code) != SRC_BAD) sw <= src_e'(wr_code);
            if (sw != sws && target_rdy) sws <= sw;
        end
    end
endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
    import clkctl_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DROP_TICKS = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    input  logic [REG_W/8-1:0]   bus_be,
    input  logic                 bus_wr,
    output logic [REG_W-1:0]     bus_rdata,
    input  logic [7:0]           cal_init,
    input  logic                 int_stable,
    input  logic                 int_tick,
    input  logic                 ext_stable,
    input  logic                 lp_enter,
    input  logic                 lp_exit,
    input  logic                 ext_fail,
    output logic                 int_osc_en,
    output logic                 ext_osc_en,
    output logic [1:0]           clk_sel,
    output logic [8:0]           trim_out
);
    localparam int WORD_W = ADDR_W - 2;

    logic       sel_ctrl, sel_cfg;
    logic       wr_en_byte, wr_trim, wr_sw;
    logic       int_en, ext_en, int_en_d, ext_en_d;
    logic       int_rdy, ext_rdy, fail_hit;
    logic [4:0] trim;
    logic [7:0] cal;
    src_e       sw, sws;
    ctrl_t      rd_ctrl;
    logic       unused_bits;

    assign unused_bits = ^{bus_addr[1:0], bus_wdata[REG_W-1:13], bus_wdata[7:2], bus_be[REG_W/8-1:2]};

    assign sel_ctrl   = bus_addr[ADDR_W-1:2] == WORD_W'(CTRL_WORD);
    assign sel_cfg    = bus_addr[ADDR_W-1:2] == WORD_W'(CFG_WORD);
    assign wr_en_byte = bus_wr & sel_ctrl & bus_be[0];
    assign wr_trim    = bus_wr & sel_ctrl & bus_be[1];
    assign wr_sw      = bus_wr & sel_cfg  & bus_be[0];
    assign fail_hit   = ext_fail & needs_ext(sws);

    always_comb begin
        int_en_d = int_en;
        if (wr_en_byte) begin
            if (bus_wdata[0])                            int_en_d = 1'b1;
            else if (sws != SRC_INT && sw != SRC_INT)    int_en_d = 1'b0;
        end
        if (lp_exit || fail_hit) int_en_d = 1'b1;
    end

    always_comb begin
        ext_en_d = ext_en;
        if (wr_en_byte) begin
            if (bus_wdata[1])         ext_en_d = 1'b1;
            else if (!needs_ext(sws)) ext_en_d = 1'b0;
        end
        if (lp_enter) ext_en_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            int_en <= 1'b1;
            ext_en <= 1'b0;
            trim   <= TRIM_RST;
            cal    <= cal_init;
        end else begin
            int_en <= int_en_d;
            ext_en <= ext_en_d;
            if (wr_trim) trim <= bus_wdata[12:8];
        end
    end

    clkctl_ready #(.DROP_TICKS(DROP_TICKS)) u_int_rdy (
        .clk(clk), .rst(rst), .en(int_en), .stable(int_stable),
        .tick(int_tick), .rdy(int_rdy)
    );

    clkctl_ready #(.DROP_TICKS(0)) u_ext_rdy (
        .clk(clk), .rst(rst), .en(ext_en), .stable(ext_stable),
        .tick(1'b0), .rdy(ext_rdy)
    );

    clkctl_switch u_switch (
        .clk(clk), .rst(rst), .wr_en(wr_sw), .wr_code(bus_wdata[1:0]),
        .int_rdy(int_rdy), .ext_rdy(ext_rdy), .fail(fail_hit),
        .sw(sw), .sws(sws)
    );

    always_comb begin
        rd_ctrl         = '0;
        rd_ctrl.int_en  = int_en;
        rd_ctrl.ext_en  = ext_en;
        rd_ctrl.int_rdy = int_rdy;
        rd_ctrl.ext_rdy = ext_rdy;
        rd_ctrl.trim    = trim;
        rd_ctrl.cal     = cal;
    end

    always_comb begin
        if (sel_ctrl)     bus_rdata = rd_ctrl;
        else if (sel_cfg) bus_rdata = {{(REG_W-4){1'b0}}, sws, sw};
        else              bus_rdata = '0;
    end

    assign int_osc_en = int_en;
    assign ext_osc_en = ext_en;
    assign clk_sel    = sws;
    assign trim_out   = {1'b0, cal} + {4'b0, trim};
endmodule

// File: rtl/clk_src_ctrl_chk.sv
module clk_src_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       int_en,
    input logic       ext_en,
    input logic       int_rdy,
    input logic       ext_rdy,
    input logic       int_stable,
    input logic       ext_stable,
    input logic       int_tick,
    input logic       lp_enter,
    input logic       lp_exit,
    input logic       ext_fail,
    input logic [1:0] sw,
    input logic [1:0] sws
);
    p_int_rise_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(int_rdy) |-> $past(int_en && int_stable));
    p_ext_rise_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_rdy) |-> $past(ext_en && ext_stable));
    p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (rst)
        (!int_en && int_rdy && !int_tick) |=> int_rdy);
    p_exit_on_r4: assert property (@(posedge clk) disable iff (rst)
        lp_exit |=> int_en);
    p_enter_off_r5: assert property (@(posedge clk) disable iff (rst)
        lp_enter |=> !ext_en);
    p_int_kept_r6: assert property (@(posedge clk) disable iff (rst)
        ((sws == 2'b00 || sw == 2'b00) && int_en) |=> int_en);
    p_ext_kept_r7: assert property (@(posedge clk) disable iff (rst)
        ((sws == 2'b01 || sws == 2'b10) && ext_en && !lp_enter) |=> ext_en);
    p_fallback_r8: assert property (@(posedge clk) disable iff (rst)
        (ext_fail && (sws == 2'b01 || sws == 2'b10)) |=> (sws == 2'b00 && sw == 2'b00 && int_en));
    p_switch_ready_r9: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sws) && !$past(ext_fail)) |->
            (sws == $past(sw) && ((sws == 2'b00) ? $past(int_rdy) : $past(ext_rdy))));
    p_no_code3_r9: assert property (@(posedge clk) disable iff (rst)
        sw != 2'b11 && sws != 2'b11);
endmodule

bind clk_src_ctrl clk_src_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .int_en(int_en), .ext_en(ext_en),
    .int_rdy(int_rdy), .ext_rdy(ext_rdy), .int_stable(int_stable),
    .ext_stable(ext_stable), .int_tick(int_tick), .lp_enter(lp_enter),
    .lp_exit(lp_exit), .ext_fail(ext_fail), .sw(sw), .sws(sws)
);

// File: tb/tb_clk_src_ctrl.sv
`timescale 1ns/1ps
module tb_clk_src_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_rdata;
    logic [7:0]  cal_init = 8'hA5;
    logic        int_stable = 1'b0, int_tick = 1'b0, ext_stable = 1'b0;
    logic        lp_enter = 1'b0, lp_exit = 1'b0, ext_fail = 1'b0;
    logic        int_osc_en, ext_osc_en;
    logic [1:0]  clk_sel;
    logic [8:0]  trim_out;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0, armed = 0;

    always #4 clk = ~clk;

    clk_src_ctrl dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_be(bus_be), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
        .cal_init(cal_init), .int_stable(int_stable), .int_tick(int_tick),
        .ext_stable(ext_stable), .lp_enter(lp_enter), .lp_exit(lp_exit),
        .ext_fail(ext_fail), .int_osc_en(int_osc_en), .ext_osc_en(ext_osc_en),
        .clk_sel(clk_sel), .trim_out(trim_out)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // oscillator stand-ins: stable follows enable after a delay; tick every third cycle
    logic [2:0] int_q = '0;
    logic [3:0] ext_q = '0;
    always @(negedge clk) begin
        int_q      = {int_q[1:0], int_osc_en};
        ext_q      = {ext_q[2:0], ext_osc_en};
        int_stable = int_q[2];
        ext_stable = ext_q[3];
        int_tick   = (cyc % 3) == 0;
    end

    // behavioural reference
    bit m_int_en, m_ext_en, m_int_rdy, m_ext_rdy;
    int m_cnt, m_sw, m_sws, m_trim, m_cal;

    always @(posedge clk) begin
        cyc++;
        armed = 1;
        if (rst) begin
            m_int_en = 1; m_ext_en = 0; m_int_rdy = 0; m_ext_rdy = 0;
            m_cnt = 0; m_sw = 0; m_sws = 0; m_trim = 16; m_cal = cal_init;
        end else begin
            bit p_int_en, p_ext_en, p_int_rdy, p_ext_rdy, wctl, wcfg, hit;
            int p_sw, p_sws;
            p_int_en = m_int_en; p_ext_en = m_ext_en;
            p_int_rdy = m_int_rdy; p_ext_rdy = m_ext_rdy;
            p_sw = m_sw; p_sws = m_sws;
            wctl = bus_wr && bus_addr == 8'h00;
            wcfg = bus_wr && bus_addr == 8'h04;
            hit  = ext_fail && (p_sws == 1 || p_sws == 2);
            if (wctl && bus_be[0]) begin
                if (bus_wdata[0]) m_int_en = 1;
                else if (p_sws != 0 && p_sw != 0) m_int_en = 0;
                if (bus_wdata[1]) m_ext_en = 1;
                else if (!(p_sws == 1 || p_sws == 2)) m_ext_en = 0;
            end
            if (lp_exit || hit) m_int_en = 1;
            if (lp_enter) m_ext_en = 0;
            if (wctl && bus_be[1]) m_trim = bus_wdata[12:8];
            if (p_int_en) begin
                m_int_rdy = int_stable; m_cnt = 0;
            end else if (p_int_rdy && int_tick) begin
                m_cnt++;
                if (m_cnt == 6) begin m_int_rdy = 0; m_cnt = 0; end
            end
            m_ext_rdy = p_ext_en && ext_stable;
            if (hit) begin
                m_sw = 0; m_sws = 0;
            end else begin
                if (p_sw != p_sws && ((p_sw == 0) ? p_int_rdy : p_ext_rdy)) m_sws = p_sw;
                if (wcfg && bus_be[0] && bus_wdata[1:0] != 2'b11) m_sw = bus_wdata[1:0];
            end
        end
    end

    function automatic logic [31:0] m_read(logic [7:0] a);
        if (a == 8'h00)
            return {8'h00, m_cal[7:0], 3'b000, m_trim[4:0], 2'b00, m_ext_rdy, m_int_rdy, 2'b00, m_ext_en, m_int_en};
        if (a == 8'h04)
            return {28'h0, m_sws[1:0], m_sw[1:0]};
        return 32'h0;
    endfunction

    // per-cycle comparison, away from both edges
    always @(negedge clk) begin
        #2;
        if (armed && !done) begin
            chk("R6 int_osc_en", {31'b0, int_osc_en}, {31'b0, m_int_en});
            chk("R7 ext_osc_en", {31'b0, ext_osc_en}, {31'b0, m_ext_en});
            chk("R9 clk_sel", {30'b0, clk_sel}, m_sws);
            chk("R10 trim_out", {23'b0, trim_out}, m_cal + m_trim);
            chk("R11 bus_rdata", bus_rdata, m_read(bus_addr));
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] be);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0; bus_addr = 8'h00;
    endtask

    task automatic rd(string tag, logic [7:0] a, logic [31:0] mask, logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata & mask, exp);
    endtask

    initial begin
        idle(4);
        rst = 1'b0;
        // R1 reset state
        rd("R1 ctrl reset", 8'h00, 32'hFFFF_FFEF, 32'h00A5_1001);
        rd("R1 cfg reset", 8'h04, 32'hFFFF_FFFF, 32'h0);
        chk("R10 trim sum", {23'b0, trim_out}, 32'h0B5);
        idle(6);
        rd("R2 int ready up", 8'h00, 32'h10, 32'h10);
        // R6 clear of on-die enable refused while it is the source
        wr(8'h00, 32'h0, 4'b0001);
        idle(1);
        chk("R6 int kept", {31'b0, int_osc_en}, 32'h1);
        // R2 enable off-die, ready bits in the write are discarded
        wr(8'h00, 32'h33, 4'b0001);
        rd("R2 ext not ready yet", 8'h00, 32'h20, 32'h0);
        idle(8);
        rd("R2 ext ready", 8'h00, 32'h33, 32'h33);
        // R9 switch to off-die, status lags one cycle
        wr(8'h04, 32'h1, 4'b0001);
        chk("R9 status lag", {30'b0, clk_sel}, 32'h0);
        idle(1);
        chk("R9 status follows", {30'b0, clk_sel}, 32'h1);
        wr(8'h04, 32'h3, 4'b0001);
        idle(1);
        rd("R9 code 11 discarded", 8'h04, 32'hF, 32'h5);
        // R7 clear of off-die refused while it feeds the clock
        wr(8'h00, 32'h1, 4'b0001);
        idle(1);
        chk("R7 ext kept", {31'b0, ext_osc_en}, 32'h1);
        // R3 on-die disable now allowed; ready lingers
        wr(8'h00, 32'h2, 4'b0001);
        idle(3);
        rd("R3 ready lingers", 8'h00, 32'h11, 32'h10);
        idle(25);
        rd("R3 ready dropped", 8'h00, 32'h11, 32'h00);
        // R8 failure fallback
        @(negedge clk); ext_fail = 1'b1;
        @(negedge clk); ext_fail = 1'b0;
        chk("R8 status 00", {30'b0, clk_sel}, 32'h0);
        chk("R8 int forced on", {31'b0, int_osc_en}, 32'h1);
        rd("R8 request 00", 8'h04, 32'h3, 32'h0);
        idle(6);
        // R9 indirect source, R7 applies to it too
        wr(8'h04, 32'h2, 4'b0001);
        idle(2);
        chk("R9 indirect source", {30'b0, clk_sel}, 32'h2);
        wr(8'h00, 32'h1, 4'b0001);
        idle(1);
        chk("R7 ext kept indirect", {31'b0, ext_osc_en}, 32'h1);
        wr(8'h00, 32'h2, 4'b0001);
        // R5 low-power entry wins over a write setting the enable
        @(negedge clk);
        bus_addr = 8'h00; bus_wdata = 32'h2; bus_be = 4'b0001; bus_wr = 1'b1; lp_enter = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0; lp_enter = 1'b0;
        chk("R5 ext off", {31'b0, ext_osc_en}, 32'h0);
        idle(2);
        // R4 low-power exit wins over a write clearing the enable
        @(negedge clk);
        bus_wdata = 32'h0; bus_be = 4'b0001; bus_wr = 1'b1; lp_exit = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0; lp_exit = 1'b0;
        chk("R4 int on", {31'b0, int_osc_en}, 32'h1);
        idle(6);
        // R3 re-enable inside the window keeps ready up
        wr(8'h00, 32'h0, 4'b0001);
        idle(6);
        wr(8'h00, 32'h1, 4'b0001);
        idle(12);
        rd("R3 re-enable keeps ready", 8'h00, 32'h11, 32'h11);
        wr(8'h04, 32'h0, 4'b0001);
        idle(2);
        chk("R9 back to on-die", {30'b0, clk_sel}, 32'h0);
        // R10 trim lanes
        wr(8'h00, 32'h0000_0500, 4'b0010);
        idle(1);
        chk("R10 trim write", {23'b0, trim_out}, 32'h0AA);
        wr(8'h00, 32'h0000_1F01, 4'b0001);
        idle(1);
        chk("R10 lane gated", {23'b0, trim_out}, 32'h0AA);
        // R11 unmapped word
        rd("R11 unmapped", 8'h08, 32'hFFFF_FFFF, 32'h0);
        idle(2);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule